// File: doc/BRIEF.md
# Multiplexed Register Bus Port

This block is the slave side of a narrow parallel bus that an external microcontroller uses to program a video timing controller. One 8-bit set of lines carries the address first and the data second. Two strobes frame the transfer. The block brings both strobes into its own clock domain, latches the address when the address strobe goes low, and writes the data into the addressed register when the data strobe goes low.

The registers hold six 9-bit vertical start/stop values. Their low bytes each have their own address. Their ninth bits are all gathered into one packed register, which is written separately. The six assembled values are presented side by side on one flat output for the timing logic.

One command address does not select a register. Instead it sets up a single read transfer on the next address/data cycle. During that transfer the data strobe acts as an active-low read enable, and the block drives the two upper bus lines with the current field identification flags. After that one transfer the port returns to write-only behaviour.

Top module: `mux_reg_port`

## Requirements
- R1: After reset, every assembled value on `vals_o` is zero and `hi_oe` is low.
- R2: The address is taken from `bus_i` when `ale_i` falls. The data is taken from `bus_i` when `wrs_i` falls. Either capture is visible at the outputs within four clock cycles. Addresses 0x40 to 0x45 load the low byte of value 0 to value 5, in that order. Value k sits at `vals_o[9k+8:9k]`.
- R3: Address 0x46 loads the ninth bits. Bit k of the data becomes bit 8 of value k, for k = 0 to 5. Data bits 6 and 7 are dropped. Writes to other addresses leave all ninth bits unchanged.
- R4: A data transfer to any address outside 0x40 to 0x46 leaves every value unchanged.
- R5: After an address cycle carrying 0x80, the next address/data cycle is a read, whatever address it carries. While `wrs_i` is low in that read, `hi_oe` is high and `hi_o` is {`fld100_i`, `fld50_i`}: bit 1 is the 100 Hz flag and bit 0 is the 50 Hz flag.
- R6: The data strobe of a read transfer writes no register.
- R7: Read mode ends when the strobe of that read rises. The next address/data cycle writes normally.
- R8: Outside a read transfer with the strobe low, `hi_oe` is low and `hi_o` is zero. This holds even after 0x80 has been sent, up until the read strobe.
- R9: An address cycle on its own, with no data strobe, changes no value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale_i | input | 1 | Address strobe, asynchronous, falling edge latches the address |
| wrs_i | input | 1 | Data strobe, asynchronous, falling edge writes (read enable in read mode) |
| bus_i | input | 8 | Multiplexed address/data lines as seen by the block |
| fld50_i | input | 1 | Current 50 Hz field flag |
| fld100_i | input | 1 | Current 100 Hz field flag |
| hi_o | output | 2 | Read data for the two upper bus lines |
| hi_oe | output | 1 | Output enable for the two upper bus lines |
| vals_o | output | 54 | Six assembled 9-bit values, value k at bits 9k+8:9k |

## Verification
Register writes are tried with a distinct byte at every low address. These show that the decode is right and that no two addresses alias. Packed ninth-bit patterns 0x05 and 0xFA then show that each bit lands on its own value, that the two unused bits are dropped, and that clearing works as well as setting. Transfers to the addresses just below and just above the map show that the decode bounds are exact.

Two read sequences use opposite field flag settings, which shows the bit order on `hi_o`. Each is followed by a plain write, which shows that read mode ends after one transfer. A bare address cycle, and a data strobe on the command address itself, show that arming alone neither drives the bus nor writes anything.

// File: rtl/mux_reg_port.sv
module mux_reg_port #(
  parameter int DW        = 8,
  parameter int NREG      = 6,
  parameter int BASE_ADDR = 'h40,
  parameter int READ_CMD  = 'h80
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ale_i,
  input  logic                   wrs_i,
  input  logic [DW-1:0]          bus_i,
  input  logic                   fld50_i,
  input  logic                   fld100_i,
  output logic [1:0]             hi_o,
  output logic                   hi_oe,
  output logic [NREG*(DW+1)-1:0] vals_o
);
  localparam int VW = DW + 1;
  localparam logic [DW-1:0] RD_CMD   = DW'(READ_CMD);
  localparam logic [DW-1:0] MSB_ADDR = DW'(BASE_ADDR + NREG);
  localparam logic [DW-1:0] LO_ADDR  = DW'(BASE_ADDR);

  logic [2:0]      ale_sy, st_sy;
  logic [DW-1:0]   addr_q;
  logic            arm_q, rdc_q;
  logic [NREG-1:0] msb_q;

  wire ale_fall = ale_sy[2] & ~ale_sy[1];
  wire st_fall  = st_sy[2]  & ~st_sy[1];
  wire st_rise  = ~st_sy[2] &  st_sy[1];
  wire wr_en    = st_fall & ~rdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_sy <= '1;
      st_sy  <= '1;
    end else begin
      ale_sy <= {ale_sy[1:0], ale_i};
      st_sy  <= {st_sy[1:0], wrs_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      arm_q  <= 1'b0;
      rdc_q  <= 1'b0;
    end else begin
      if (st_rise && rdc_q) rdc_q <= 1'b0;
      if (ale_fall) begin
        addr_q <= bus_i;
        arm_q  <= (bus_i == RD_CMD);
        rdc_q  <= arm_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) msb_q <= '0;
    else if (wr_en && addr_q == MSB_ADDR) msb_q <= bus_i[NREG-1:0];
  end

  for (genvar k = 0; k < NREG; k++) begin : g_val
    localparam logic [DW-1:0] MY_ADDR = DW'(BASE_ADDR + k);
    logic [DW-1:0] lo_q;
    always_ff @(posedge clk) begin
      if (!rst_n) lo_q <= '0;
      else if (wr_en && addr_q == MY_ADDR) lo_q <= bus_i;
    end
    assign vals_o[k*VW +: VW] = {msb_q[k], lo_q};
  end

  assign hi_oe = rdc_q & ~st_sy[1];
  assign hi_o  = hi_oe ? {fld100_i, fld50_i} : 2'b00;

  // R9
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_fall |=> $stable(vals_o));

  // R6
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdc_q |=> $stable(vals_o));

  // R4
  unmapped_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fall && (addr_q < LO_ADDR || addr_q > MSB_ADDR)) |=> $stable(vals_o));

  // R3
  msb_only_own_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fall && addr_q != MSB_ADDR) |=> $stable(msb_q));

  // R7
  read_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hi_oe) && !ale_fall) |=> !rdc_q);

  // R5
  read_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdc_q) |-> $past(arm_q));
endmodule

// File: tb/mux_reg_port_test.sv
module mux_reg_port_test;
  localparam int PER = 10;

  logic clk = 1'b0, rst_n = 1'b0, ale = 1'b0, wrs = 1'b1;
  logic [7:0] bus = '0;
  logic f50 = 1'b0, f100 = 1'b0;
  logic [1:0] hi;
  logic oe;
  logic [53:0] vals;

  mux_reg_port uut (
    .clk(clk), .rst_n(rst_n), .ale_i(ale), .wrs_i(wrs), .bus_i(bus),
    .fld50_i(f50), .fld100_i(f100), .hi_o(hi), .hi_oe(oe), .vals_o(vals)
  );

  always #(PER/2) clk = ~clk;

  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  // {addr, data, value index, expected 9-bit value}
  localparam logic [27:0] VEC [13] = '{
    {8'h40, 8'h12, 3'd0, 9'h012}, {8'h41, 8'h34, 3'd1, 9'h034},
    {8'h42, 8'h56, 3'd2, 9'h056}, {8'h43, 8'h78, 3'd3, 9'h078},
    {8'h44, 8'h9A, 3'd4, 9'h09A}, {8'h45, 8'hBC, 3'd5, 9'h0BC},
    {8'h46, 8'h05, 3'd0, 9'h112}, {8'h46, 8'h05, 3'd2, 9'h156},
    {8'h46, 8'hFA, 3'd1, 9'h134}, {8'h46, 8'hFA, 3'd5, 9'h1BC},
    {8'h47, 8'hFF, 3'd5, 9'h1BC}, {8'h3F, 8'hFF, 3'd0, 9'h012},
    {8'h40, 8'hFF, 3'd0, 9'h0FF}
  };

  function automatic logic [8:0] val(input int k);
    return vals[k*9 +: 9];
  endfunction

  task automatic chk(input string req, input logic [53:0] act, input logic [53:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [7:0] a);
    bus = a; ale = 1'b1; waitc(4);
    ale = 1'b0; waitc(4);
  endtask

  task automatic data_low(input logic [7:0] d);
    bus = d; wrs = 1'b0; waitc(5);
  endtask

  task automatic data_high();
    wrs = 1'b1; waitc(5);
  endtask

  initial begin
    logic [53:0] snap;
    waitc(3);
    rst_n = 1'b1;
    waitc(2);
    // R1
    chk("R1 values", vals, '0);
    chk("R1 oe", {53'd0, oe}, '0);

    // R2 R3 R4 table
    for (int i = 0; i < 13; i++) begin
      addr_phase(VEC[i][27:20]);
      data_low(VEC[i][19:12]);
      data_high();
      chk("R2/R3/R4 table", {45'd0, val(int'(VEC[i][11:9]))}, {45'd0, VEC[i][8:0]});
    end

    // R9: address cycle alone changes nothing
    snap = vals;
    addr_phase(8'h41);
    chk("R9 ale only", vals, snap);

    // R8: command address armed, no bus drive yet; its own strobe writes nothing
    addr_phase(8'h80);
    chk("R8 armed oe", {52'd0, oe, hi}, '0);
    data_low(8'h41);
    chk("R8 cmd strobe oe", {52'd0, oe, hi}, '0);
    data_high();
    chk("R4 cmd strobe", vals, snap);

    // R5 R6: read transfer with 50 Hz flag set
    f50 = 1'b1; f100 = 1'b0;
    addr_phase(8'h80);
    addr_phase(8'h44);
    data_low(8'h00);
    chk("R5 read 50", {51'd0, oe, hi}, {51'd0, 1'b1, 2'b01});
    data_high();
    chk("R6 no write", vals, snap);
    chk("R8 oe after read", {52'd0, oe, hi}, '0);

    // R7: next cycle writes normally (ninth bit of value 4 is set)
    addr_phase(8'h44);
    data_low(8'h11);
    chk("R7 oe low on write", {53'd0, oe}, '0);
    data_high();
    chk("R7 write after read", {45'd0, val(4)}, {45'd0, 9'h111});

    // R5: opposite flag order
    f50 = 1'b0; f100 = 1'b1;
    snap = vals;
    addr_phase(8'h80);
    addr_phase(8'h40);
    data_low(8'h77);
    chk("R5 read 100", {51'd0, oe, hi}, {51'd0, 1'b1, 2'b10});
    data_high();
    chk("R6 no write 2", vals, snap);
    addr_phase(8'h40);
    data_low(8'h77);
    data_high();
    chk("R7 write value 0", {45'd0, val(0)}, {45'd0, 9'h077});
    chk("R8 idle hi", {51'd0, oe, hi}, '0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    #(PER * 100000);
    if (!done) begin
      done = 1'b1;
      nvec++; nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule